// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block keeps a free-running 32-bit time counter and records timestamped events in a small queue. An event is recorded when software asks for one, when the counter passes its midpoint or wraps, when one of four hardware pins rises, or when the Ethernet receive or transmit path signals that a timing frame went by. Each stored event carries the counter value plus a descriptor: what kind of event it was, which port or pin caused it, and for Ethernet events the frame's message type and sequence number.

Software uses a plain 32-bit register port. It writes one word per cycle and reads back combinationally from the address it presents. It looks at the oldest queued event through two read-only words, then writes a pop strobe to drop that event. A level interrupt stays high while events are waiting, gated by an enable bit. Several sources can fire in the same cycle. Each source then waits in its own one-entry holding slot, and the slots drain into the queue one per cycle in a fixed priority order.

Top module: `evtStampUnit`

## Requirements
- R1: While the run bit (bit 0 of the control word at 0x04) is set, the counter increases by one on every clock edge. While the run bit is clear, the counter holds its value.
- R2: Writing 1 to bit 0 of 0x14 copies the load word (0x10) into the counter on that edge. The load wins over the increment, and a load never creates a midpoint or wrap event.
- R3: While running, writing 1 to bit 0 of 0x0C queues a kind-0 event. Its stamp is the counter value just before the write edge, and its port, message and sequence fields are zero.
- R4: A counter step from 0x7FFFFFFF to 0x80000000 queues a kind-2 event stamped 0x80000000. A step from 0xFFFFFFFF to 0 queues a kind-1 event stamped 0.
- R5: Each hardware pin i (0..3) passes through two synchronizing flops. A rising edge on pin i queues a kind-3 event with port field i+1, but only if the run bit and enable bit 8+i of the control word are both set.
- R6: A receive strobe queues kind 4 and a transmit strobe queues kind 5. Each takes the port, message type and sequence number presented with it, and is stamped with the counter value before that edge.
- R7: The event high word (0x38) packs port in bits 28:24, kind in 23:20, message type in 19:16 and sequence in 15:0. The low word (0x34) holds the stamp. Both words read zero while the queue is empty.
- R8: The queue holds 16 events. Writing 1 to bit 0 of 0x30 drops the oldest event. An event that arrives when the queue is full is lost and sets a sticky overflow bit (bit 1 of 0x20), which is cleared by writing 1 to that bit.
- R9: Sources drain one per cycle in this order: push, wrap, midpoint, pins 1 to 4, receive, transmit. If a source fires while its own slot is still waiting, the new event is lost and the overflow bit is set.
- R10: Bit 0 of 0x20 is (queue not empty) OR (test bit, control bit 1). Bit 0 of 0x24 is that value ANDed with bit 0 of 0x28, and the interrupt output follows 0x24 bit 0.
- R11: Word 0x00 reads a fixed identity: id in 31:16, revision in 15:11, major in 10:8 and minor in 7:0.
- R12: While the run bit is clear, push writes, receive and transmit strobes, and pin edges queue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte address of the register word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| hwPin | input | 4 | Asynchronous hardware push pins |
| rxStrobe | input | 1 | Receive timestamp strobe |
| rxPort | input | 5 | Receive port number |
| rxMsgType | input | 4 | Receive message type |
| rxSeqId | input | 16 | Receive sequence number |
| txStrobe | input | 1 | Transmit timestamp strobe |
| txPort | input | 5 | Transmit port number |
| txMsgType | input | 4 | Transmit message type |
| txSeqId | input | 16 | Transmit sequence number |
| intOut | output | 1 | Level interrupt |

## Verification
The bench loads the counter just below its midpoint and just below its wrap. A design that compared the wrong counter value, or raised events on a load, would stamp 0x7FFFFFFF or queue a spurious marker. It fires push, receive and transmit together on two consecutive cycles, so the queue order and the lost-while-waiting rule are both exercised. It then fills the queue past 16 entries: a design that overwrote stored events, or failed to make the overflow bit sticky, would show the wrong head or a clear bit 1. Writes made while the run bit is clear, and a rising edge on a pin whose enable bit is off, must leave the queue empty.

// File: rtl/evtStampPkg.sv
package evtStampPkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HW_PINS = 4;
  localparam int SRC_PUSH = 0;
  localparam int SRC_WRAP = 1;
  localparam int SRC_MID = 2;
  localparam int SRC_PIN0 = 3;
  localparam int SRC_RX = SRC_PIN0 + HW_PINS;
  localparam int SRC_TX = SRC_RX + 1;
  localparam int SRC_NUM = SRC_TX + 1;

  localparam logic [7:0] A_IDENT = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_PUSH = 8'h0C;
  localparam logic [7:0] A_LDVAL = 8'h10;
  localparam logic [7:0] A_LDGO = 8'h14;
  localparam logic [7:0] A_RAW = 8'h20;
  localparam logic [7:0] A_MASKED = 8'h24;
  localparam logic [7:0] A_IEN = 8'h28;
  localparam logic [7:0] A_POP = 8'h30;
  localparam logic [7:0] A_EVLO = 8'h34;
  localparam logic [7:0] A_EVHI = 8'h38;

  typedef enum logic [3:0] {
    EV_SWPUSH = 4'd0,
    EV_WRAP   = 4'd1,
    EV_MID    = 4'd2,
    EV_PIN    = 4'd3,
    EV_ETHRX  = 4'd4,
    EV_ETHTX  = 4'd5
  } evKind_t;

  typedef struct packed {
    logic [4:0]  portNum;
    evKind_t     kind;
    logic [3:0]  msgType;
    logic [15:0] seqId;
    logic [31:0] stamp;
  } evRec_t;

  typedef struct packed {
    logic               cntRun;
    logic               cntLoad;
    logic               swPush;
    logic               popHead;
    logic               ovfClear;
    logic [HW_PINS-1:0] pinFire;
    logic               rxFire;
    logic               txFire;
  } ctlStb_t;

  function automatic logic [31:0] packHigh(evRec_t r);
    return {3'b000, r.portNum, r.kind, r.msgType, r.seqId};
  endfunction
endpackage

// File: rtl/evtStampCtrl.sv
module evtStampCtrl
  import evtStampPkg::*;
#(
  parameter logic [15:0] ID_VAL = 16'h4E8A,
  parameter logic [4:0]  REV_VAL = 5'd3,
  parameter logic [2:0]  MAJ_VAL = 3'd1,
  parameter logic [7:0]  MIN_VAL = 8'd2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [HW_PINS-1:0] hwPin,
  input  logic               rxStrobe,
  input  logic               txStrobe,
  input  logic               fifoEmpty,
  input  logic               ovfFlag,
  input  evRec_t             headRec,
  output ctlStb_t            stb,
  output logic [31:0]        loadVal,
  output logic               intOut
);
  timeunit 1ns;
  timeprecision 100ps;

  logic               unitRun;
  logic               intTest;
  logic               intEn;
  logic [HW_PINS-1:0] pinEn;
  logic [HW_PINS-1:0] sync0, sync1, prevQ;
  logic               rawPend;
  logic [31:0]        ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitRun <= 1'b0;
      intTest <= 1'b0;
      intEn   <= 1'b0;
      pinEn   <= '0;
      loadVal <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_CTRL) begin
        unitRun <= regWrData[0];
        intTest <= regWrData[1];
        pinEn   <= regWrData[8 +: HW_PINS];
      end
      if (regAddr == A_IEN) intEn <= regWrData[0];
      if (regAddr == A_LDVAL) loadVal <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync0 <= '0;
      sync1 <= '0;
      prevQ <= '0;
    end else begin
      sync0 <= hwPin;
      sync1 <= sync0;
      prevQ <= sync1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.cntRun   = unitRun;
    stb.cntLoad  = regWrEn && regAddr == A_LDGO && regWrData[0];
    stb.swPush   = unitRun && regWrEn && regAddr == A_PUSH && regWrData[0];
    stb.popHead  = regWrEn && regAddr == A_POP && regWrData[0];
    stb.ovfClear = regWrEn && regAddr == A_RAW && regWrData[1];
    stb.pinFire  = sync1 & ~prevQ & pinEn & {HW_PINS{unitRun}};
    stb.rxFire   = unitRun && rxStrobe;
    stb.txFire   = unitRun && txStrobe;
  end

  assign rawPend = !fifoEmpty || intTest;
  assign intOut  = rawPend && intEn;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = unitRun;
    ctrlWord[1] = intTest;
    ctrlWord[8 +: HW_PINS] = pinEn;
  end

  always_comb begin
    case (regAddr)
      A_IDENT:  regRdData = {ID_VAL, REV_VAL, MAJ_VAL, MIN_VAL};
      A_CTRL:   regRdData = ctrlWord;
      A_LDVAL:  regRdData = loadVal;
      A_RAW:    regRdData = {30'd0, ovfFlag, rawPend};
      A_MASKED: regRdData = {31'd0, intOut};
      A_IEN:    regRdData = {31'd0, intEn};
      A_EVLO:   regRdData = headRec.stamp;
      A_EVHI:   regRdData = packHigh(headRec);
      default:  regRdData = '0;
    endcase
  end

  // R10: with the enable bit clear the interrupt line stays low
  p_irq_gate_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !intOut);

  for (genvar i = 0; i < HW_PINS; i++) begin : g_pinChk
    // R5: a pin edge produces a single-cycle fire strobe
    p_pin_pulse_r5 : assert property (@(posedge clk) disable iff (!rstN)
      stb.pinFire[i] |=> !stb.pinFire[i]);
  end
endmodule

// File: rtl/evtStampData.sv
module evtStampData
  import evtStampPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStb_t     stb,
  input  logic [31:0] loadVal,
  input  logic [4:0]  rxPort,
  input  logic [3:0]  rxMsgType,
  input  logic [15:0] rxSeqId,
  input  logic [4:0]  txPort,
  input  logic [3:0]  txMsgType,
  input  logic [15:0] txSeqId,
  output evRec_t      headRec,
  output logic        fifoEmpty,
  output logic        ovfFlag
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [31:0]        cnt;
  logic [SRC_NUM-1:0] srcFire, pendQ, grant;
  evRec_t             srcRec [SRC_NUM];
  evRec_t             pendRec [SRC_NUM];
  evRec_t             grantRec;
  evRec_t             mem [DEPTH];
  logic [PW-1:0]      rdPtr, wrPtr;
  logic [CW-1:0]      count;
  logic               fifoFull, doWr, doRd, dropGrant, collision;

  // time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (stb.cntLoad) cnt <= loadVal;
    else if (stb.cntRun) cnt <= cnt + 32'd1;
  end

  // event sources
  always_comb begin
    for (int s = 0; s < SRC_NUM; s++) begin
      srcRec[s] = '0;
      srcRec[s].stamp = cnt;
    end
    srcFire = '0;
    srcFire[SRC_PUSH] = stb.swPush;
    srcFire[SRC_WRAP] = stb.cntRun && !stb.cntLoad && cnt == 32'hFFFF_FFFF;
    srcRec[SRC_WRAP].kind = EV_WRAP;
    srcRec[SRC_WRAP].stamp = 32'h0000_0000;
    srcFire[SRC_MID] = stb.cntRun && !stb.cntLoad && cnt == 32'h7FFF_FFFF;
    srcRec[SRC_MID].kind = EV_MID;
    srcRec[SRC_MID].stamp = 32'h8000_0000;
    for (int i = 0; i < HW_PINS; i++) begin
      srcFire[SRC_PIN0+i] = stb.pinFire[i];
      srcRec[SRC_PIN0+i].kind = EV_PIN;
      srcRec[SRC_PIN0+i].portNum = 5'(i + 1);
    end
    srcFire[SRC_RX] = stb.rxFire;
    srcRec[SRC_RX].kind = EV_ETHRX;
    srcRec[SRC_RX].portNum = rxPort;
    srcRec[SRC_RX].msgType = rxMsgType;
    srcRec[SRC_RX].seqId = rxSeqId;
    srcFire[SRC_TX] = stb.txFire;
    srcRec[SRC_TX].kind = EV_ETHTX;
    srcRec[SRC_TX].portNum = txPort;
    srcRec[SRC_TX].msgType = txMsgType;
    srcRec[SRC_TX].seqId = txSeqId;
  end

  // one holding slot per source
  for (genvar s = 0; s < SRC_NUM; s++) begin : g_slot
    logic   slotBusy;
    evRec_t slotRec;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotBusy <= 1'b0;
        slotRec  <= '0;
      end else if (srcFire[s] && (!slotBusy || grant[s])) begin
        slotBusy <= 1'b1;
        slotRec  <= srcRec[s];
      end else if (grant[s]) begin
        slotBusy <= 1'b0;
      end
    end
    assign pendQ[s]   = slotBusy;
    assign pendRec[s] = slotRec;
  end

  // fixed-priority drain, lowest index first
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    grantRec = '0;
    for (int s = 0; s < SRC_NUM; s++) begin
      if (pendQ[s] && !found) begin
        found = 1'b1;
        grant[s] = 1'b1;
        grantRec = pendRec[s];
      end
    end
  end

  assign fifoFull  = count == FULL_CNT;
  assign fifoEmpty = count == '0;
  assign doWr      = |grant && !fifoFull;
  assign dropGrant = |grant && fifoFull;
  assign doRd      = stb.popHead && !fifoEmpty;
  assign collision = |(srcFire & pendQ & ~grant);

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= grantRec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      if (doWr && !doRd) count <= count + 1'b1;
      else if (doRd && !doWr) count <= count - 1'b1;
      ovfFlag <= (ovfFlag && !stb.ovfClear) || dropGrant || collision;
    end
  end

  assign headRec = fifoEmpty ? '0 : mem[rdPtr];

  // R1: counter steps by one while running
  p_cnt_step_r1 : assert property (@(posedge clk) disable iff (!rstN)
    stb.cntRun && !stb.cntLoad |=> cnt == $past(cnt) + 32'd1);
  // R1: counter holds while stopped
  p_cnt_hold_r1 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntRun && !stb.cntLoad |=> $stable(cnt));
  // R2: load copies the load word
  p_cnt_load_r2 : assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoad |=> cnt == $past(loadVal));
  // R8: a full queue with no pop stays full
  p_no_overflow_r8 : assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && !stb.popHead |=> fifoFull);
endmodule

// File: rtl/evtStampUnit.sv
module evtStampUnit
  import evtStampPkg::*;
#(
  parameter int          DEPTH = 16,
  parameter logic [15:0] ID_VAL = 16'h4E8A,
  parameter logic [4:0]  REV_VAL = 5'd3,
  parameter logic [2:0]  MAJ_VAL = 3'd1,
  parameter logic [7:0]  MIN_VAL = 8'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [3:0]  hwPin,
  input  logic        rxStrobe,
  input  logic [4:0]  rxPort,
  input  logic [3:0]  rxMsgType,
  input  logic [15:0] rxSeqId,
  input  logic        txStrobe,
  input  logic [4:0]  txPort,
  input  logic [3:0]  txMsgType,
  input  logic [15:0] txSeqId,
  output logic        intOut
);
  timeunit 1ns;
  timeprecision 100ps;

  ctlStb_t     stb;
  evRec_t      headRec;
  logic        fifoEmpty;
  logic        ovfFlag;
  logic [31:0] loadVal;

  evtStampCtrl #(
    .ID_VAL(ID_VAL), .REV_VAL(REV_VAL), .MAJ_VAL(MAJ_VAL), .MIN_VAL(MIN_VAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hwPin(hwPin),
    .rxStrobe(rxStrobe), .txStrobe(txStrobe), .fifoEmpty(fifoEmpty),
    .ovfFlag(ovfFlag), .headRec(headRec), .stb(stb), .loadVal(loadVal),
    .intOut(intOut)
  );

  evtStampData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadVal),
    .rxPort(rxPort), .rxMsgType(rxMsgType), .rxSeqId(rxSeqId),
    .txPort(txPort), .txMsgType(txMsgType), .txSeqId(txSeqId),
    .headRec(headRec), .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/test_evtStampUnit.sv
module test_evtStampUnit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 16;
  localparam logic [31:0] IDWORD = {16'h4E8A, 5'd3, 3'd1, 8'd2};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [3:0]  hwPin = '0;
  logic        rxStrobe = 1'b0, txStrobe = 1'b0;
  logic [4:0]  rxPort = '0, txPort = '0;
  logic [3:0]  rxMsgType = '0, txMsgType = '0;
  logic [15:0] rxSeqId = '0, txSeqId = '0;
  wire  [31:0] regRdData;
  wire         intOut;

  evtStampUnit i_evtStampUnit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hwPin(hwPin),
    .rxStrobe(rxStrobe), .rxPort(rxPort), .rxMsgType(rxMsgType), .rxSeqId(rxSeqId),
    .txStrobe(txStrobe), .txPort(txPort), .txMsgType(txMsgType), .txSeqId(txSeqId),
    .intOut(intOut)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R10";

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCnt = '0, mLd = '0;
  bit          mRun = 0, mTest = 0, mIen = 0, mOvf = 0;
  bit   [3:0]  mPinEn = '0, mS0 = '0, mS1 = '0, mPrev = '0;
  bit          mPend [9] = '{default: 1'b0};
  logic [31:0] mPLo [9] = '{default: '0};
  logic [31:0] mPHi [9] = '{default: '0};
  logic [31:0] qLo [$];
  logic [31:0] qHi [$];

  function automatic logic [31:0] expRead(input logic [7:0] a);
    bit raw;
    raw = (qLo.size() != 0) || mTest;
    case (a)
      8'h00: return IDWORD;
      8'h04: return {20'd0, mPinEn, 6'd0, mTest, mRun};
      8'h10: return mLd;
      8'h20: return {30'd0, mOvf, raw};
      8'h24: return {31'd0, raw & mIen};
      8'h28: return {31'd0, mIen};
      8'h34: return (qLo.size() != 0) ? qLo[0] : 32'd0;
      8'h38: return (qHi.size() != 0) ? qHi[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mLd = '0; mRun = 0; mTest = 0; mIen = 0; mOvf = 0;
      mPinEn = '0; mS0 = '0; mS1 = '0; mPrev = '0;
      for (int s = 0; s < 9; s++) mPend[s] = 0;
      qLo.delete(); qHi.delete();
    end else begin
      bit fire [9];
      logic [31:0] fLo [9];
      logic [31:0] fHi [9];
      bit ld, full, setOvf;
      int g;
      setOvf = 0;
      for (int s = 0; s < 9; s++) begin fire[s] = 0; fLo[s] = mCnt; fHi[s] = 0; end
      ld = regWrEn && regAddr == 8'h14 && regWrData[0];
      if (mRun && regWrEn && regAddr == 8'h0C && regWrData[0]) fire[0] = 1;
      if (mRun && !ld && mCnt == 32'hFFFF_FFFF) begin fire[1] = 1; fLo[1] = 0; fHi[1] = 32'h0010_0000; end
      if (mRun && !ld && mCnt == 32'h7FFF_FFFF) begin fire[2] = 1; fLo[2] = 32'h8000_0000; fHi[2] = 32'h0020_0000; end
      for (int i = 0; i < 4; i++)
        if (mRun && mPinEn[i] && mS1[i] && !mPrev[i]) begin
          fire[3+i] = 1; fHi[3+i] = ((i + 1) << 24) | 32'h0030_0000;
        end
      if (mRun && rxStrobe) begin
        fire[7] = 1; fHi[7] = (32'(rxPort) << 24) | (32'd4 << 20) | (32'(rxMsgType) << 16) | 32'(rxSeqId);
      end
      if (mRun && txStrobe) begin
        fire[8] = 1; fHi[8] = (32'(txPort) << 24) | (32'd5 << 20) | (32'(txMsgType) << 16) | 32'(txSeqId);
      end
      g = -1;
      for (int s = 0; s < 9; s++) if (mPend[s] && g < 0) g = s;
      full = qLo.size() == DEPTH;
      if (regWrEn && regAddr == 8'h30 && regWrData[0] && qLo.size() != 0) begin
        void'(qLo.pop_front()); void'(qHi.pop_front());
      end
      if (g >= 0) begin
        if (!full) begin qLo.push_back(mPLo[g]); qHi.push_back(mPHi[g]); end
        else setOvf = 1;
        mPend[g] = 0;
      end
      for (int s = 0; s < 9; s++)
        if (fire[s]) begin
          if (mPend[s]) setOvf = 1;
          else begin mPend[s] = 1; mPLo[s] = fLo[s]; mPHi[s] = fHi[s]; end
        end
      if (regWrEn && regAddr == 8'h20 && regWrData[1]) mOvf = 0;
      if (setOvf) mOvf = 1;
      if (ld) mCnt = mLd;
      else if (mRun) mCnt = mCnt + 1;
      if (regWrEn && regAddr == 8'h04) begin
        mRun = regWrData[0]; mTest = regWrData[1]; mPinEn = regWrData[11:8];
      end
      if (regWrEn && regAddr == 8'h28) mIen = regWrData[0];
      if (regWrEn && regAddr == 8'h10) mLd = regWrData;
      mPrev = mS1; mS1 = mS0; mS0 = hwPin;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!done) begin
      chk(regRdData, expRead(regAddr), "per-cycle read");
      chk({31'd0, intOut}, {31'd0, expRead(8'h24) != 0}, "per-cycle interrupt");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #0.5;
    regWrEn = 1'b0;
  endtask

  task automatic burst(input logic [7:0] a, input int n);
    @(negedge clk); #0.5;
    regWrEn = 1'b1; regAddr = a; regWrData = 32'd1;
    repeat (n) @(posedge clk);
    #0.5 regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] e, input string what);
    @(negedge clk); #1;
    regAddr = a;
    #0.5 chk(regRdData, e, what);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trio(input int n);
    @(negedge clk); #0.5;
    regWrEn = 1'b1; regAddr = 8'h0C; regWrData = 32'd1;
    rxStrobe = 1'b1; rxPort = 5'd3; rxMsgType = 4'h2; rxSeqId = 16'hBEEF;
    txStrobe = 1'b1; txPort = 5'd5; txMsgType = 4'h9; txSeqId = 16'h1234;
    repeat (n) @(posedge clk);
    #0.5 regWrEn = 1'b0; rxStrobe = 1'b0; txStrobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rstN = 1'b1;
    curReq = "R11";
    peek(8'h00, IDWORD, "identity word");
    curReq = "R10";
    peek(8'h20, 32'd0, "raw status after reset");

    curReq = "R12";
    wr(8'h10, 32'h55); wr(8'h14, 1); wr(8'h0C, 1);
    @(negedge clk); #0.5 rxStrobe = 1'b1; @(posedge clk); #0.5 rxStrobe = 1'b0;
    idle(3);
    peek(8'h20, 32'd0, "stopped unit queued nothing");

    curReq = "R3";
    wr(8'h04, 1); wr(8'h0C, 1);
    idle(3);
    peek(8'h34, 32'h55, "push stamp");
    peek(8'h38, 32'h0, "push high word");
    wr(8'h30, 1);

    curReq = "R1";
    wr(8'h04, 0); wr(8'h10, 32'h1000); wr(8'h14, 1); wr(8'h04, 1);
    wr(8'h0C, 1); idle(4); wr(8'h0C, 1);
    peek(8'h34, 32'h1000, "first stamp");
    wr(8'h30, 1);
    peek(8'h34, 32'h1005, "stamp five edges later");
    wr(8'h30, 1);

    curReq = "R4";
    wr(8'h10, 32'h7FFF_FFFE); wr(8'h14, 1); idle(4);
    peek(8'h38, 32'h0020_0000, "midpoint kind");
    peek(8'h34, 32'h8000_0000, "midpoint stamp");
    wr(8'h30, 1);
    wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 1); idle(4);
    peek(8'h38, 32'h0010_0000, "wrap kind");
    peek(8'h34, 32'h0, "wrap stamp");
    wr(8'h30, 1);

    curReq = "R5";
    wr(8'h04, 32'h0F01);
    @(negedge clk); #0.5 hwPin = 4'b0010;
    idle(6);
    peek(8'h38, 32'h0230_0000, "pin 2 event");
    wr(8'h30, 1);
    @(negedge clk); #0.5 hwPin = 4'b0000;
    wr(8'h04, 32'h0D01);
    idle(3);
    @(negedge clk); #0.5 hwPin = 4'b0010;
    idle(6);
    peek(8'h20, 32'd0, "disabled pin ignored");
    @(negedge clk); #0.5 hwPin = 4'b0000;
    wr(8'h04, 32'h0001);

    curReq = "R6";
    trio(1); idle(4);
    peek(8'h38, 32'h0, "push drains first");
    wr(8'h30, 1);
    peek(8'h38, 32'h0342_BEEF, "receive high word");
    wr(8'h30, 1);
    peek(8'h38, 32'h0559_1234, "transmit high word");
    wr(8'h30, 1);

    curReq = "R9";
    trio(2); idle(6);
    peek(8'h20, 32'h3, "collision sets overflow");
    peek(8'h38, 32'h0, "order push");
    wr(8'h30, 1);
    peek(8'h38, 32'h0, "order second push");
    wr(8'h30, 1);
    peek(8'h38, 32'h0342_BEEF, "order receive");
    wr(8'h30, 1);
    peek(8'h38, 32'h0559_1234, "order transmit");
    wr(8'h30, 1);
    wr(8'h20, 32'h2);
    peek(8'h20, 32'h0, "overflow cleared");

    curReq = "R8";
    burst(8'h0C, 20); idle(3);
    peek(8'h20, 32'h3, "full queue overflow");
    burst(8'h30, 16); idle(2);
    peek(8'h20, 32'h2, "sticky overflow after drain");
    curReq = "R7";
    peek(8'h34, 32'h0, "empty low word");
    peek(8'h38, 32'h0, "empty high word");
    curReq = "R8";
    wr(8'h20, 32'h2);
    peek(8'h20, 32'h0, "overflow write-one clear");

    curReq = "R10";
    wr(8'h28, 1); wr(8'h04, 32'h3);
    peek(8'h24, 32'h1, "test bit masked status");
    chk({31'd0, intOut}, 32'd1, "interrupt high");
    wr(8'h28, 0);
    peek(8'h24, 32'h0, "enable cleared");
    chk({31'd0, intOut}, 32'd0, "interrupt low");
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule